// File: doc/BRIEF.md
# Quadrature Decoder Position Counter

This block turns the two phase signals of an incremental encoder, plus its once-per-revolution index signal, into a signed-direction position count. The phase inputs are assumed to be already noise-filtered and synchronous to the block clock. Each phase transition becomes an up or down step. The steps drive an up/down position counter whose width is a parameter (16 bits by default).

A three-bit mode input selects the behaviour:
- The block can be off.
- It can count at double resolution (edges of phase A only) or quadruple resolution (every edge of either phase).
- In match-reset modes the counter folds around a programmable maximum.
- In index-reset modes a qualified index pulse clears the counter.

The index pulse qualifies only when the phase levels agree with a two-bit pattern. That pattern is read differently at double and quadruple resolution. When both phases change in the same sample, the transition is illegal. In the index modes such a transition sets a sticky error flag and raises a maskable one-cycle error pulse. A one-cycle event pulse marks every counter reset, whether it comes from a fold or from the index.

Top module: `quad_pos_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `position` becomes 0, `dir_up` 0, `count_err` 0, and `err_evt` and `reset_evt` 0.
- R2: At quadruple resolution (mode bits [2:1] = 11), every single-phase change counts once. With (A,B) levels, forward is the sequence 00→10→11→01→00 and steps up. The reverse order steps down. The count changes at the clock edge that samples the new level.
- R3: At double resolution (mode 100 or 101), only a phase A change counts. A phase B change alone leaves the count unchanged. The step is up when the new A level differs from B, and down otherwise.
- R4: Mode codes 000, 001, 010 and 011 leave `position` and `dir_up` unchanged, whatever the phases or index do.
- R5: When `swap_ab` is 1, `phase_b` acts as phase A and `phase_a` acts as phase B, for both counting and index matching.
- R6: In modes 101 and 111, an up step from a count equal to `max_count` gives 0, and a down step from 0 gives `max_count`. In modes 100 and 110, the count wraps modulo 2^16.
- R7: In modes 100 and 110 with `idx_rst_en` = 1, a rising edge of the qualified index clears `position` to 0 at that clock edge, taking priority over a step. With `idx_rst_en` = 0, or in any other mode, the index has no effect on the count.
- R8: The index qualifies at quadruple resolution when the A level equals `idx_match[0]` and the B level equals `idx_match[1]`. At double resolution it qualifies when the phase chosen by `idx_match[1]` (0 = A, 1 = B) has the level `idx_match[0]`.
- R9: `dir_up` becomes 1 after an up step and 0 after a down step, and holds between steps.
- R10: In modes 100 and 110, a sample where both phases change sets `count_err` and does not step. The flag stays set until a clock edge with `err_clear` = 1 and no new error. In modes 101 and 111 such a sample sets nothing.
- R11: `err_evt` is high for exactly the one cycle following an error sample of R10, unless `err_irq_mask` is 1.
- R12: `reset_evt` is high for exactly the one cycle after the counter is cleared by the index or folded by a max-count match (R6, R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_a | input | 1 | Filtered phase A level |
| phase_b | input | 1 | Filtered phase B level |
| index_in | input | 1 | Filtered index level |
| mode | input | 3 | Operating mode code |
| swap_ab | input | 1 | Exchange the two phase inputs |
| idx_rst_en | input | 1 | Allow a qualified index to clear the count |
| idx_match | input | 2 | Phase pattern that qualifies the index |
| max_count | input | CNT_W | Fold value for the match-reset modes |
| err_clear | input | 1 | Clear the sticky count-error flag |
| err_irq_mask | input | 1 | Suppress the error pulse |
| position | output | CNT_W | Position count |
| dir_up | output | 1 | Last step direction, 1 = positive |
| count_err | output | 1 | Sticky illegal-transition flag |
| err_evt | output | 1 | One-cycle count-error pulse |
| reset_evt | output | 1 | One-cycle counter-reset pulse |

## Verification
The bench builds the block with the default 16-bit counter and drives a small `max_count` of 5. This keeps the up-fold and down-fold of the match modes within a few steps. At the same time, the index modes stepping down from 0 reach the full-width wrap to 0xFFFF. That wrap then becomes the non-zero starting value that later index clears and ignored indexes are measured against.

// File: rtl/qpc_pkg.sv
// Shared mode decoding for the quadrature position counter.
// Assumes the mode code layout: bit 2 enables decoding, bit 1 picks
// quadruple resolution, bit 0 picks max-count folding over index reset.
package qpc_pkg;

    typedef struct packed {
        logic quad_en;   // decoding active
        logic x4;        // count edges of both phases
        logic max_rst;   // fold around max_count
        logic idx_mode;  // index may clear, errors are tracked
    } qpc_mode_t;

    function automatic qpc_mode_t qpc_decode_mode(input logic [2:0] code);
        qpc_mode_t m;
        m.quad_en  = code[2];
        m.x4       = code[2] & code[1];
        m.max_rst  = code[2] & code[0];
        m.idx_mode = code[2] & ~code[0];
        return m;
    endfunction

endpackage

// File: rtl/qpc_phase_decode.sv
// Phase decoder: optional A/B swap, previous-level register, and
// conversion of single-phase changes into up/down steps.
// Assumes phases are synchronous and filtered; the previous-level
// register tracks the inputs even in reset so enabling causes no step.
module qpc_phase_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic a_raw,
    input  logic b_raw,
    input  logic swap,
    input  logic quad_en,
    input  logic x4,
    output logic a_cur,
    output logic b_cur,
    output logic step_up,
    output logic step_dn,
    output logic both_chg
);

    logic a_prev;
    logic b_prev;
    logic a_chg;
    logic b_chg;
    logic cnt_a;
    logic cnt_b;
    logic differ;

    // Route the raw inputs through the swap selector.
    always_comb begin
        a_cur = swap ? b_raw : a_raw;
        b_cur = swap ? a_raw : b_raw;
    end

    // Remember the last sampled phase levels.
    always_ff @(posedge clk) begin
        a_prev <= a_cur;
        b_prev <= b_cur;
    end

    // Classify the change and derive the step direction.
    always_comb begin
        a_chg    = a_cur ^ a_prev;
        b_chg    = b_cur ^ b_prev;
        both_chg = a_chg & b_chg;
        cnt_a    = quad_en & a_chg & ~b_chg;
        cnt_b    = quad_en & x4 & b_chg & ~a_chg;
        differ   = a_cur ^ b_cur;
        step_up  = (cnt_a & differ) | (cnt_b & ~differ);
        step_dn  = (cnt_a & ~differ) | (cnt_b & differ);
    end

    // R3: at double resolution, a sample without an A change never steps.
    assert_x2_ignores_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!x4 && a_cur == a_prev) |-> !(step_up || step_dn));

    // R10: a double change never produces a step.
    assert_no_step_on_double_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cur != a_prev && b_cur != b_prev) |-> !(step_up || step_dn));

endmodule

// File: rtl/qpc_index_qual.sv
// Index qualifier: compares the phase levels against the match pattern
// (read per resolution) and emits a one-cycle fire on the rising edge
// of the qualified index. Assumes levels are synchronous.
module qpc_index_qual (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       index_lvl,
    input  logic       a_cur,
    input  logic       b_cur,
    input  logic       x4,
    input  logic [1:0] match,
    output logic       idx_fire
);

    logic pat_ok;
    logic qual;
    logic qual_q;

    // Evaluate the pattern: both levels at x4, one selected phase at x2.
    always_comb begin
        if (x4)
            pat_ok = (a_cur == match[0]) && (b_cur == match[1]);
        else
            pat_ok = ((match[1] ? b_cur : a_cur) == match[0]);
        qual     = index_lvl & pat_ok;
        idx_fire = qual & ~qual_q;
    end

    // Hold the previous qualified level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) qual_q <= 1'b0;
        else        qual_q <= qual;
    end

    // R7: a fire is a single-cycle edge, never two cycles in a row.
    assert_fire_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_fire |=> !idx_fire);

endmodule

// File: rtl/qpc_pos_count.sv
// Position counter: applies steps, max-count folding and index clears,
// keeps the direction status and pulses reset_evt on each clear/fold.
// Assumes step_up and step_dn are never both high.
module qpc_pos_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             quad_en,
    input  logic             max_rst,
    input  logic             idx_mode,
    input  logic             idx_rst_en,
    input  logic             idx_fire,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic [CNT_W-1:0] max_count,
    output logic [CNT_W-1:0] position,
    output logic             dir_up,
    output logic             reset_evt
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic idx_clear;

    // Index clear applies only in the index modes with the enable set.
    always_comb idx_clear = quad_en & idx_mode & idx_rst_en & idx_fire;

    // Update count, direction and the reset event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            position  <= ZERO;
            dir_up    <= 1'b0;
            reset_evt <= 1'b0;
        end else begin
            reset_evt <= 1'b0;
            if (quad_en) begin
                if (step_up)      dir_up <= 1'b1;
                else if (step_dn) dir_up <= 1'b0;
                if (idx_clear) begin
                    position  <= ZERO;
                    reset_evt <= 1'b1;
                end else if (step_up) begin
                    if (max_rst && position == max_count) begin
                        position  <= ZERO;
                        reset_evt <= 1'b1;
                    end else begin
                        position <= position + ONE;
                    end
                end else if (step_dn) begin
                    if (max_rst && position == ZERO) begin
                        position  <= max_count;
                        reset_evt <= 1'b1;
                    end else begin
                        position <= position - ONE;
                    end
                end
            end
        end
    end

    assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_en |=> ($stable(position) && $stable(dir_up)));

    assert_fold_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (quad_en && max_rst && step_up && position == max_count) |=> position == ZERO);

    assert_index_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (quad_en && idx_mode && idx_rst_en && idx_fire) |=> (position == ZERO && reset_evt));

    assert_dir_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (quad_en && step_up) |=> dir_up);

    assert_dir_dn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (quad_en && step_dn) |=> !dir_up);

endmodule

// File: rtl/quad_pos_counter.sv
// Top of the quadrature position counter: mode decode, phase decoder,
// index qualifier, position counter and the sticky count-error flag.
// Assumes filtered, synchronous phase and index inputs.
module quad_pos_counter
    import qpc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             index_in,
    input  logic [2:0]       mode,
    input  logic             swap_ab,
    input  logic             idx_rst_en,
    input  logic [1:0]       idx_match,
    input  logic [CNT_W-1:0] max_count,
    input  logic             err_clear,
    input  logic             err_irq_mask,
    output logic [CNT_W-1:0] position,
    output logic             dir_up,
    output logic             count_err,
    output logic             err_evt,
    output logic             reset_evt
);

    qpc_mode_t m;
    logic a_cur;
    logic b_cur;
    logic step_up;
    logic step_dn;
    logic both_chg;
    logic idx_fire;
    logic err_hit;

    // Split the mode code into its control bits.
    always_comb m = qpc_decode_mode(mode);

    qpc_phase_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_raw    (phase_a),
        .b_raw    (phase_b),
        .swap     (swap_ab),
        .quad_en  (m.quad_en),
        .x4       (m.x4),
        .a_cur    (a_cur),
        .b_cur    (b_cur),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .both_chg (both_chg)
    );

    qpc_index_qual u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .index_lvl (index_in),
        .a_cur     (a_cur),
        .b_cur     (b_cur),
        .x4        (m.x4),
        .match     (idx_match),
        .idx_fire  (idx_fire)
    );

    qpc_pos_count #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .quad_en    (m.quad_en),
        .max_rst    (m.max_rst),
        .idx_mode   (m.idx_mode),
        .idx_rst_en (idx_rst_en),
        .idx_fire   (idx_fire),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .max_count  (max_count),
        .position   (position),
        .dir_up     (dir_up),
        .reset_evt  (reset_evt)
    );

    // Errors are tracked only in the index modes.
    always_comb err_hit = m.idx_mode & both_chg;

    // Sticky error flag (set wins over clear) and its maskable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_err <= 1'b0;
            err_evt   <= 1'b0;
        end else begin
            err_evt <= err_hit & ~err_irq_mask;
            if (err_hit)        count_err <= 1'b1;
            else if (err_clear) count_err <= 1'b0;
        end
    end

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_err && !err_clear) |=> count_err);

    assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |-> count_err);

endmodule

// File: tb/test_quad_pos_counter.sv
module test_quad_pos_counter;

    localparam int CNT_W = 16;
    localparam int NV    = 37;
    // Vector fields: mode[3] swap a b idx match[2] pos[16] dir evt
    localparam logic [26:0] VECS [0:NV-1] = '{
        {3'd7,1'b0,1'b1,1'b0,1'b0,2'd0,16'd1,1'b1,1'b0},
        {3'd7,1'b0,1'b1,1'b1,1'b0,2'd0,16'd2,1'b1,1'b0},
        {3'd7,1'b0,1'b0,1'b1,1'b0,2'd0,16'd3,1'b1,1'b0},
        {3'd7,1'b0,1'b0,1'b0,1'b0,2'd0,16'd4,1'b1,1'b0},
        {3'd7,1'b0,1'b1,1'b0,1'b0,2'd0,16'd5,1'b1,1'b0},
        {3'd7,1'b0,1'b1,1'b1,1'b0,2'd0,16'd0,1'b1,1'b1},
        {3'd7,1'b0,1'b1,1'b0,1'b0,2'd0,16'd5,1'b0,1'b1},
        {3'd7,1'b0,1'b0,1'b0,1'b0,2'd0,16'd4,1'b0,1'b0},
        {3'd7,1'b0,1'b0,1'b0,1'b0,2'd0,16'd4,1'b0,1'b0},
        {3'd5,1'b0,1'b0,1'b1,1'b0,2'd0,16'd4,1'b0,1'b0},
        {3'd5,1'b0,1'b1,1'b1,1'b0,2'd0,16'd3,1'b0,1'b0},
        {3'd5,1'b0,1'b1,1'b0,1'b0,2'd0,16'd3,1'b0,1'b0},
        {3'd5,1'b0,1'b0,1'b0,1'b0,2'd0,16'd2,1'b0,1'b0},
        {3'd5,1'b0,1'b1,1'b0,1'b0,2'd0,16'd3,1'b1,1'b0},
        {3'd0,1'b0,1'b0,1'b0,1'b0,2'd0,16'd3,1'b1,1'b0},
        {3'd0,1'b0,1'b1,1'b0,1'b0,2'd0,16'd3,1'b1,1'b0},
        {3'd3,1'b0,1'b1,1'b1,1'b0,2'd0,16'd3,1'b1,1'b0},
        {3'd1,1'b0,1'b0,1'b1,1'b0,2'd0,16'd3,1'b1,1'b0},
        {3'd7,1'b1,1'b1,1'b0,1'b0,2'd0,16'd3,1'b1,1'b0},
        {3'd7,1'b1,1'b1,1'b1,1'b0,2'd0,16'd2,1'b0,1'b0},
        {3'd7,1'b0,1'b1,1'b1,1'b0,2'd0,16'd2,1'b0,1'b0},
        {3'd6,1'b0,1'b1,1'b1,1'b1,2'd0,16'd2,1'b0,1'b0},
        {3'd6,1'b0,1'b0,1'b1,1'b0,2'd0,16'd3,1'b1,1'b0},
        {3'd6,1'b0,1'b0,1'b0,1'b1,2'd0,16'd0,1'b1,1'b1},
        {3'd6,1'b0,1'b0,1'b0,1'b1,2'd0,16'd0,1'b1,1'b0},
        {3'd6,1'b0,1'b0,1'b0,1'b0,2'd0,16'd0,1'b1,1'b0},
        {3'd6,1'b0,1'b0,1'b1,1'b0,2'd0,16'hFFFF,1'b0,1'b0},
        {3'd4,1'b0,1'b1,1'b1,1'b1,2'd3,16'd0,1'b0,1'b1},
        {3'd4,1'b0,1'b1,1'b1,1'b0,2'd3,16'd0,1'b0,1'b0},
        {3'd4,1'b0,1'b0,1'b1,1'b0,2'd3,16'd1,1'b1,1'b0},
        {3'd4,1'b0,1'b0,1'b0,1'b1,2'd3,16'd1,1'b1,1'b0},
        {3'd4,1'b0,1'b0,1'b1,1'b1,2'd3,16'd0,1'b1,1'b1},
        {3'd4,1'b0,1'b1,1'b1,1'b0,2'd2,16'hFFFF,1'b0,1'b0},
        {3'd4,1'b0,1'b1,1'b1,1'b1,2'd2,16'hFFFF,1'b0,1'b0},
        {3'd4,1'b0,1'b1,1'b1,1'b1,2'd1,16'd0,1'b0,1'b1},
        {3'd7,1'b0,1'b0,1'b1,1'b0,2'd3,16'd1,1'b1,1'b0},
        {3'd7,1'b0,1'b0,1'b1,1'b1,2'd2,16'd1,1'b1,1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             phase_a = 1'b0;
    logic             phase_b = 1'b0;
    logic             index_in = 1'b0;
    logic [2:0]       mode = 3'd0;
    logic             swap_ab = 1'b0;
    logic             idx_rst_en = 1'b1;
    logic [1:0]       idx_match = 2'd0;
    logic [CNT_W-1:0] max_count = 16'd5;
    logic             err_clear = 1'b0;
    logic             err_irq_mask = 1'b0;
    logic [CNT_W-1:0] position;
    logic             dir_up;
    logic             count_err;
    logic             err_evt;
    logic             reset_evt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    quad_pos_counter #(.CNT_W(CNT_W)) i_quad_pos_counter (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .index_in(index_in), .mode(mode), .swap_ab(swap_ab),
        .idx_rst_en(idx_rst_en), .idx_match(idx_match), .max_count(max_count),
        .err_clear(err_clear), .err_irq_mask(err_irq_mask),
        .position(position), .dir_up(dir_up), .count_err(count_err),
        .err_evt(err_evt), .reset_evt(reset_evt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, then sample just after the next rising edge.
    task automatic drive(input logic [2:0] md, input logic a, input logic b, input logic ix);
        @(negedge clk);
        mode = md; phase_a = a; phase_b = b; index_in = ix;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pos", position, 0);
        chk("R1 dir", dir_up, 0);
        chk("R1 err", count_err, 0);
        chk("R1 evt", {err_evt, reset_evt}, 0);
        @(negedge clk) rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R12
        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VECS[i];
            @(negedge clk);
            mode = v[26:24]; swap_ab = v[23]; phase_a = v[22]; phase_b = v[21];
            index_in = v[20]; idx_match = v[19:18];
            @(posedge clk);
            #1;
            chk($sformatf("R2/R3/R4/R5/R6/R7/R8 pos vec%0d", i), position, v[17:2]);
            chk($sformatf("R9 dir vec%0d", i), dir_up, v[1]);
            chk($sformatf("R12 reset_evt vec%0d", i), reset_evt, v[0]);
        end

        // R10 R11: double change in index mode sets the flag and pulses
        drive(3'd6, 1'b1, 1'b0, 1'b0);
        chk("R10 err set", count_err, 1);
        chk("R11 err pulse", err_evt, 1);
        chk("R10 no step", position, 1);
        drive(3'd6, 1'b1, 1'b0, 1'b0);
        chk("R10 sticky", count_err, 1);
        chk("R11 one cycle", err_evt, 0);
        @(negedge clk) err_clear = 1'b1;
        @(posedge clk); #1;
        chk("R10 cleared", count_err, 0);
        @(negedge clk) err_clear = 1'b0;
        drive(3'd7, 1'b0, 1'b1, 1'b0);
        chk("R10 match mode no flag", count_err, 0);
        chk("R10 match mode no step", position, 1);
        @(negedge clk) err_irq_mask = 1'b1;
        drive(3'd4, 1'b1, 1'b0, 1'b0);
        chk("R10 x2 err set", count_err, 1);
        chk("R11 masked", err_evt, 0);
        @(negedge clk) begin err_clear = 1'b1; err_irq_mask = 1'b0; end
        @(posedge clk); #1;
        @(negedge clk) err_clear = 1'b0;

        // R7: disabled index reset leaves the count, enabled clears it
        @(negedge clk) begin idx_rst_en = 1'b0; idx_match = 2'b01; end
        drive(3'd6, 1'b1, 1'b0, 1'b1);
        chk("R7 enable off", position, 1);
        chk("R12 no evt", reset_evt, 0);
        @(negedge clk) idx_rst_en = 1'b1;
        drive(3'd6, 1'b1, 1'b0, 1'b0);
        chk("R7 idle", position, 1);
        drive(3'd6, 1'b1, 1'b0, 1'b1);
        chk("R7 enable on", position, 0);
        chk("R12 evt", reset_evt, 1);
        drive(3'd6, 1'b1, 1'b1, 1'b0);
        chk("R2 step after clear", position, 1);
        chk("R9 dir up", dir_up, 1);

        // R1: mid-run reset
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 mid pos", position, 0);
        chk("R1 mid dir", dir_up, 0);
        chk("R1 mid err", count_err, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule